// File: doc/BRIEF.md
# Shift-Add Block FIR Filter (16 taps, 4 samples per cycle)

This block is a fixed-coefficient FIR filter that consumes four new input samples on every clock and returns four filtered outputs on every clock. It is organised as a block transpose structure. The sixteen taps are split into four sub-filters of four taps each. Each of the seven samples in the current window (the four new ones plus the three newest of the previous block) drives its own constant-multiplier bank. Each bank produces every coefficient product that sample needs, using only shifts, additions and subtractions taken from a canonical signed-digit recoding of each constant. An adder network combines those products into one partial inner product for each output row and each sub-filter. A pipelined adder chain then folds the partial products of later sub-filters in with one-block delays.

The coefficients are package constants fixed at elaboration, so no tap selection or general multiplier exists. Inputs are 16-bit signed and outputs are kept at full precision (36-bit signed), so no rounding or wrap happens anywhere.

Top module: `mcm_block_fir`

## Requirements
- R1: `din` carries four 16-bit signed samples. Lane l sits in bits [16l+15:16l], and lane 0 holds the newest sample, so within one block lane l is x(n−l) where n is the newest sample index. `dout` uses the same lane order: lane l (bits [36l+35:36l]) is y(n−l).
- R2: Every output is y(t) = Σ h(i)·x(t−i) for i = 0..15, with h = {−32768, 32767, 1, 0, −1, 12345, −21846, 4096, 255, −256, 7, −3, 20000, −9999, 16384, −32767} for i = 0..15.
- R3: A block applied to `din` at rising edge e appears on `dout` after edge e+1 and stays there for one cycle. The first output after reset release therefore comes from all-zero history.
- R4: Outputs are 36-bit signed two's complement and exact for every input pattern, including sign-matched full-scale inputs whose sum exceeds 32 bits.
- R5: A synchronous reset asserted in mid-stream erases all history. Samples applied before the reset contribute nothing to any output after it.
- R6: While `rst` is high, and in the cycle it is released, `dout` is zero.
- R7: Outputs depend on samples from up to four earlier blocks, carried across block boundaries without loss, for any sequence of blocks.
- R8: Products are formed without multipliers. A unit input (+1 or −1) in any lane yields exactly ±h(i) at the matching output positions, and a zero input yields zero products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears history and outputs |
| din | input | 64 | Four signed input samples, lane 0 newest |
| dout | output | 144 | Four signed 36-bit outputs, lane 0 newest |

## Verification
The bench targets the places where a block transpose filter typically goes wrong.

- **Impulses in each lane, positive and negative.** A swapped lane order or a wrong tail-sample mapping would move coefficients into the wrong output slot. A faulty signed-digit recoding would corrupt one tap, and that is most likely for the −32768 and −32767 constants.
- **Sign-matched full-scale runs.** These expose an accumulator that has been narrowed to 32 bits.
- **Long random runs.** These exercise the carry of partial sums across block boundaries, where a misplaced delay in the adder chain shifts a sub-filter's contribution by one block.
- **A reset in mid-stream followed by an impulse.** This shows whether stale samples or stale partial sums survive the reset.
- **Output timing.** The output is checked one cycle too early, which catches an extra or missing register stage.

// File: rtl/blkfir_pkg.sv
package blkfir_pkg;

    localparam int SW    = 16;                 // sample width
    localparam int CW    = 16;                 // coefficient width
    localparam int NTAP  = 16;                 // filter length
    localparam int LBLK  = 4;                  // samples per block
    localparam int MSUB  = NTAP / LBLK;        // number of sub-filters
    localparam int WIN   = 2 * LBLK - 1;       // samples in the overlapped window
    localparam int AW    = SW + CW + $clog2(NTAP);  // full-precision accumulator width

    typedef logic signed [SW-1:0] smp_t;
    typedef logic signed [AW-1:0] acc_t;

    // Canonical signed-digit recoding: one plus-mask and one minus-mask.
    typedef struct packed {
        logic [CW:0] pos;
        logic [CW:0] neg;
    } csd_t;

    localparam logic signed [CW-1:0] TAPS [NTAP] = '{
        16'sh8000,  16'sd32767,  16'sd1,      16'sd0,
        -16'sd1,    16'sd12345,  -16'sd21846, 16'sd4096,
        16'sd255,   -16'sd256,   16'sd7,      -16'sd3,
        16'sd20000, -16'sd9999,  16'sd16384,  -16'sd32767
    };

    function automatic csd_t csd_of(input logic signed [CW-1:0] c);
        csd_t r;
        int   rem;
        int   dig;
        r   = '0;
        rem = int'(c);
        for (int i = 0; i <= CW; i++) begin
            if ((rem & 1) != 0) begin
                dig = 2 - (rem & 3);
                if (dig > 0) r.pos[i] = 1'b1;
                else         r.neg[i] = 1'b1;
                rem = rem - dig;
            end
            rem = rem >>> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/blkfir_mcm_bank.sv
// Constant-multiplier bank for one window sample at distance DIST from the
// newest sample. One shifted-sample ladder is shared by every product.
module blkfir_mcm_bank
    import blkfir_pkg::*;
#(
    parameter int DIST = 0
) (
    input  smp_t x,
    output acc_t prod [LBLK][MSUB]   // [tap within sub-filter][sub-filter]
);

    acc_t ladder [CW+1];

    generate
        for (genvar s = 0; s <= CW; s++) begin : g_ladder
            assign ladder[s] = acc_t'(x) <<< s;
        end

        for (genvar j = 0; j < LBLK; j++) begin : g_tap
            for (genvar m = 0; m < MSUB; m++) begin : g_sub
                if ((DIST - j) >= 0 && (DIST - j) < LBLK) begin : g_used
                    localparam csd_t DIG = csd_of(TAPS[m*LBLK+j]);
                    acc_t pv;

                    always_comb begin
                        pv = '0;
                        for (int s = 0; s <= CW; s++) begin
                            if (DIG.pos[s]) pv = pv + ladder[s];
                            if (DIG.neg[s]) pv = pv - ladder[s];
                        end
                    end
                    assign prod[j][m] = pv;

                    always_comb begin
                        if (x == '0) begin
                            // R8
                            zero_in_chk: assert (pv == '0);
                        end
                        if (x == smp_t'(1)) begin
                            // R8
                            unit_gain_chk: assert (pv == acc_t'(TAPS[m*LBLK+j]));
                        end
                        if (x == smp_t'(-1)) begin
                            // R8
                            neg_unit_chk: assert (pv == -acc_t'(TAPS[m*LBLK+j]));
                        end
                    end
                end else begin : g_unused
                    assign prod[j][m] = '0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/blkfir_ipnet.sv
// Adder network: r(l,m) = sum over j of h(m*L+j) * x(newest - l - j).
module blkfir_ipnet
    import blkfir_pkg::*;
(
    input  acc_t prd [WIN][LBLK][MSUB],   // [window distance][tap][sub-filter]
    output acc_t rip [LBLK][MSUB]         // [row][sub-filter]
);

    generate
        for (genvar l = 0; l < LBLK; l++) begin : g_row
            for (genvar m = 0; m < MSUB; m++) begin : g_sub
                acc_t s;
                always_comb begin
                    s = '0;
                    for (int j = 0; j < LBLK; j++) begin
                        s = s + prd[l+j][j][m];
                    end
                end
                assign rip[l][m] = s;
            end
        end
    endgenerate

endmodule

// File: rtl/blkfir_pau.sv
// Pipelined adder chain: later sub-filters are folded in through one-block delays.
module blkfir_pau
    import blkfir_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t rip [LBLK][MSUB],
    output acc_t y   [LBLK]
);

    generate
        for (genvar l = 0; l < LBLK; l++) begin : g_row
            acc_t part [1:MSUB-1];
            acc_t y_r;

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int m = 1; m < MSUB; m++) part[m] <= '0;
                    y_r <= '0;
                end else begin
                    part[MSUB-1] <= rip[l][MSUB-1];
                    for (int m = 1; m < MSUB - 1; m++) begin
                        part[m] <= rip[l][m] + part[m+1];
                    end
                    y_r <= rip[l][0] + part[1];
                end
            end

            assign y[l] = y_r;
        end
    endgenerate

endmodule

// File: rtl/mcm_block_fir.sv
module mcm_block_fir
    import blkfir_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LBLK*SW-1:0]   din,
    output logic [LBLK*AW-1:0]   dout
);

    smp_t blk_q  [LBLK];
    smp_t hist_q [LBLK-1];
    smp_t win    [WIN];
    acc_t prd    [WIN][LBLK][MSUB];
    acc_t rip    [LBLK][MSUB];
    acc_t y      [LBLK];
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < LBLK; l++)     blk_q[l]  <= '0;
            for (int d = 0; d < LBLK - 1; d++) hist_q[d] <= '0;
        end else begin
            for (int l = 0; l < LBLK; l++)     blk_q[l]  <= din[l*SW +: SW];
            for (int d = 0; d < LBLK - 1; d++) hist_q[d] <= blk_q[d];
        end
    end

    generate
        for (genvar d = 0; d < WIN; d++) begin : g_win
            if (d < LBLK) begin : g_cur
                assign win[d] = blk_q[d];
            end else begin : g_old
                assign win[d] = hist_q[d-LBLK];
            end

            blkfir_mcm_bank #(.DIST(d)) u_bank (
                .x    (win[d]),
                .prod (prd[d])
            );
        end

        for (genvar l = 0; l < LBLK; l++) begin : g_out
            assign dout[l*AW +: AW] = y[l];
        end
    endgenerate

    blkfir_ipnet u_ipnet (
        .prd (prd),
        .rip (rip)
    );

    blkfir_pau u_pau (
        .clk (clk),
        .rst (rst),
        .rip (rip),
        .y   (y)
    );

    // cycles since reset, for the history check below
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R7
    hist_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (hist_q[0] == $past(din[SW-1:0], 2)));

    // R6
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dout == '0));

endmodule

// File: tb/sim_mcm_block_fir.sv
module sim_mcm_block_fir;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 16;
    localparam int AW = 36;
    localparam int NB = 8192;

    logic             clk;
    logic             rst;
    logic [4*SW-1:0]  din;
    logic [4*AW-1:0]  dout;

    int checks;
    int errors;
    int xs [NB];
    int ns;
    int seg_start;
    int nblk;
    string cur_tag;
    bit done;

    int H [16] = '{-32768, 32767, 1, 0, -1, 12345, -21846, 4096,
                   255, -256, 7, -3, 20000, -9999, 16384, -32767};

    mcm_block_fir u0 (.clk(clk), .rst(rst), .din(din), .dout(dout));

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint ref_y(int n);
        longint s = 0;
        for (int i = 0; i < 16; i++) begin
            if (n - i >= seg_start) s += longint'(H[i]) * longint'(xs[n-i]);
        end
        return s;
    endfunction

    function automatic longint lane_out(int l);
        logic signed [AW-1:0] v;
        v = dout[l*AW +: AW];
        return longint'(v);
    endfunction

    function automatic int rnd16();
        logic signed [15:0] v;
        v = 16'($urandom);
        return int'(v);
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge. Checks the output that is due now, then drives one
    // block of four samples given in time order (a3 newest -> lane 0).
    task automatic push4(int a0, int a1, int a2, int a3);
        int base;
        if (nblk >= 2) begin
            base = seg_start + 4*(nblk-2);
            for (int l = 0; l < 4; l++) chk(cur_tag, lane_out(l), ref_y(base + 3 - l));
        end else if (nblk == 1) begin
            // R3: first block not yet visible one cycle after capture
            for (int l = 0; l < 4; l++) chk("R3", lane_out(l), 0);
        end
        xs[ns] = a0; xs[ns+1] = a1; xs[ns+2] = a2; xs[ns+3] = a3;
        ns += 4;
        din[0*SW +: SW] = 16'(a3);
        din[1*SW +: SW] = 16'(a2);
        din[2*SW +: SW] = 16'(a1);
        din[3*SW +: SW] = 16'(a0);
        nblk++;
        @(negedge clk);
    endtask

    task automatic flush(int nb);
        for (int b = 0; b < nb; b++) push4(0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        din = '0;
        @(negedge clk);
        // R6: zero while reset is held
        for (int l = 0; l < 4; l++) chk("R6", lane_out(l), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        seg_start = ns;
        nblk = 0;
        // R6: zero in the cycle of release
        for (int l = 0; l < 4; l++) chk("R6", lane_out(l), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seq [16];
        checks = 0; errors = 0; ns = 0; seg_start = 0; nblk = 0; done = 0;
        rst = 1'b1;
        din = '0;
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();

        // R1 R8: unit impulse in each lane position
        cur_tag = "R1 R8 impulse+1";
        for (int p = 0; p < 4; p++) begin
            push4(p == 0 ? 1 : 0, p == 1 ? 1 : 0, p == 2 ? 1 : 0, p == 3 ? 1 : 0);
            flush(6);
        end

        // R8: negative unit impulse
        cur_tag = "R8 impulse-1";
        push4(0, -1, 0, 0);
        flush(6);

        // R4: sign-matched full-scale inputs, largest magnitude outputs
        cur_tag = "R4 fullscale";
        for (int i = 0; i < 16; i++) seq[15-i] = (H[i] >= 0) ? 32767 : -32768;
        for (int b = 0; b < 4; b++) push4(seq[4*b], seq[4*b+1], seq[4*b+2], seq[4*b+3]);
        for (int i = 0; i < 16; i++) seq[15-i] = (H[i] >= 0) ? -32768 : 32767;
        for (int b = 0; b < 4; b++) push4(seq[4*b], seq[4*b+1], seq[4*b+2], seq[4*b+3]);
        for (int b = 0; b < 6; b++) push4(-32768, -32768, -32768, -32768);
        flush(6);

        // R2 R7: random stream with occasional extremes
        cur_tag = "R2 R7 random";
        for (int b = 0; b < 150; b++) begin
            if (($urandom % 8) == 0) push4(32767, -32768, rnd16(), -32768);
            else                     push4(rnd16(), rnd16(), rnd16(), rnd16());
        end
        flush(6);

        // R5: reset in mid-stream, then an impulse must show clean taps
        cur_tag = "R5 pre-reset";
        for (int b = 0; b < 10; b++) push4(rnd16(), rnd16(), rnd16(), rnd16());
        do_reset();
        cur_tag = "R5 post-reset";
        push4(0, 0, 7, 0);
        flush(6);

        // R3: isolated impulse in lane 0 right after reset, timing checked by push4
        do_reset();
        cur_tag = "R3 latency";
        push4(0, 0, 0, 1);
        flush(5);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule